// File: doc/BRIEF.md
# Burst Address Counter with Prioritized Controls

This block supplies the word address for one port of a synchronous memory during burst transfers. At every rising clock edge it picks one of four actions: clear the address to zero, take an address from outside, step the last used address by one, or repeat the last used address unchanged. The picked address is driven out straight away through logic, so an address taken from outside reaches the memory array in the same cycle it is presented. That address is also stored, and it becomes the "previous" address for the next cycle.

The three controls are active low and follow a fixed order of precedence. Clear wins over load, and load wins over step or hold. The block has no chip-enable or byte-select inputs, so selection and byte masking elsewhere never stop or alter the counting. A separate global reset clears the stored address asynchronously.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst_n` is low, the stored address is 0 at once, without waiting for a clock. With all three controls high after reset, `addr_used` then reads 0.
- R2: When `clr_n` is low, `addr_used` is 0, whatever `load_n`, `step_n` and `ext_addr` are.
- R3: When `clr_n` is high and `load_n` is low, `addr_used` equals `ext_addr` in that same cycle.
- R4: When `clr_n`, `load_n` and `step_n` are all high, `addr_used` equals the address used in the previous cycle, and `ext_addr` has no effect on it.
- R5: When `clr_n` and `load_n` are high and `step_n` is low, `addr_used` equals the previous cycle's address plus one.
- R6: Stepping from the largest address (all ones, 16383 with default width) gives 0.
- R7: The address used in a cycle is captured at the rising clock edge, and it is the previous address for the next cycle.
- R8: When several controls are low together, the precedence is clear, then load, then step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures the used address |
| rst_n | input | 1 | Asynchronous global reset, active low |
| ext_addr | input | ADDR_W (14) | Address offered from outside |
| load_n | input | 1 | Take `ext_addr`, active low |
| step_n | input | 1 | Step the previous address by one, active low |
| clr_n | input | 1 | Clear the address to zero, active low |
| addr_used | output | ADDR_W (14) | Address used in the current cycle |

## Verification
On every clock the bound checker checks how each control setting picks the used address: clear gives zero, load passes the external address through, hold repeats the captured address, and step adds one to it, including the wrap from all ones. The checker keeps its own copy of the last used address to do this. The bench scenarios cover what those per-cycle properties cannot show on their own. These are multi-cycle bursts that mix load, step and hold, precedence under random patterns where all three controls are low together, and the asynchronous global reset arriving between clock edges.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_STEP  = 2'd3
  } bac_mode_e;
endpackage

// File: rtl/bac_prio_decode.sv
module bac_prio_decode
  import bac_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      step_n,
  output bac_mode_e mode
);
  // fixed precedence: clear, then load, then step, else hold
  always_comb begin
    if (!clr_n)       mode = MODE_CLEAR;
    else if (!load_n) mode = MODE_LOAD;
    else if (!step_n) mode = MODE_STEP;
    else              mode = MODE_HOLD;
  end
endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  bac_mode_e         mode,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] prev_addr,
  output logic [ADDR_W-1:0] used_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (mode)
      MODE_CLEAR: used_addr = '0;
      MODE_LOAD:  used_addr = ext_addr;
      MODE_STEP:  used_addr = prev_addr + ONE; // natural wrap at all ones
      default:    used_addr = prev_addr;
    endcase
  end
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] addr_used
);
  bac_mode_e         mode;
  logic [ADDR_W-1:0] prev_q;

  bac_prio_decode u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .step_n (step_n),
    .mode   (mode)
  );

  bac_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .mode      (mode),
    .ext_addr  (ext_addr),
    .prev_addr (prev_q),
    .used_addr (addr_used)
  );

  bac_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (addr_used),
    .q     (prev_q)
  );
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              load_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr_used
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TOP = '1;

  // checker's own record of the last used address (R7)
  logic [ADDR_W-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= addr_used;
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> addr_used == '0);

  a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |-> addr_used == ext_addr);

  a_r4_hold_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |-> addr_used == last_q);

  a_r5_step_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |-> addr_used == ADDR_W'(last_q + ONE));

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n && last_q == TOP) |-> addr_used == '0);
endmodule

bind burst_addr_counter bac_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_addr  (ext_addr),
  .load_n    (load_n),
  .step_n    (step_n),
  .clr_n     (clr_n),
  .addr_used (addr_used)
);

// File: tb/tb_burst_addr_counter.sv
module tb_burst_addr_counter;
  localparam int AW = 14;
  localparam int NV = 13;
  // entry: {clr_n, load_n, step_n, ext_addr, expected addr_used}
  localparam logic [3+2*AW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 14'h1234, 14'h0000}, // R4 hold after reset
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h0001}, // R5
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h0002}, // R5
    {1'b1, 1'b0, 1'b1, 14'h0100, 14'h0100}, // R3
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h0101}, // R5 from loaded
    {1'b1, 1'b1, 1'b1, 14'h3FFF, 14'h0101}, // R4 ext ignored
    {1'b0, 1'b0, 1'b0, 14'h2AAA, 14'h0000}, // R8 clear wins
    {1'b1, 1'b0, 1'b0, 14'h3FFE, 14'h3FFE}, // R8 load beats step
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h3FFF}, // R5
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h0000}, // R6 wrap
    {1'b1, 1'b1, 1'b0, 14'h0000, 14'h0001}, // R5 after wrap
    {1'b0, 1'b1, 1'b1, 14'h1111, 14'h0000}, // R2
    {1'b1, 1'b1, 1'b1, 14'h2222, 14'h0000}  // R7 cleared value kept
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          load_n = 1'b1, step_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] addr_used;
  int checks = 0, fails = 0;
  logic [AW-1:0] m_prev;

  always #2.5 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .load_n(load_n), .step_n(step_n), .clr_n(clr_n), .addr_used(addr_used)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_used !== exp) begin
      fails++;
      $display("FAIL %s: addr_used=%h expected=%h", req, addr_used, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(input logic c, input logic l,
      input logic s, input logic [AW-1:0] e, input logic [AW-1:0] p);
    if (!c)      return '0;
    else if (!l) return e;
    else if (!s) return p + 1'b1;
    else         return p;
  endfunction

  // drive after the falling edge, sample 1 ns later, well before the rising edge
  task automatic apply(input logic c, input logic l, input logic s, input logic [AW-1:0] e);
    @(negedge clk);
    clr_n = c; load_n = l; step_n = s; ext_addr = e;
    #1;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check("R1 reset state", '0);
    @(negedge clk); rst_n = 1'b1;
    #1; check("R1 idle after reset", '0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][3+2*AW-1], VEC[i][2+2*AW-1], VEC[i][1+2*AW-1],
            VEC[i][2*AW-1:AW]);
      check($sformatf("R2-table vector %0d (R3 R4 R5 R6 R7 R8)", i), VEC[i][AW-1:0]);
    end

    // async global reset between edges
    apply(1'b1, 1'b0, 1'b1, 14'h0055);
    check("R3 load before async reset", 14'h0055);
    apply(1'b1, 1'b1, 1'b1, 14'h0000);
    check("R7 held loaded value", 14'h0055);
    #1 rst_n = 1'b0;
    #0.5; check("R1 async clear", '0);
    @(negedge clk); rst_n = 1'b1;
    #1; check("R1 idle after release", '0);

    // random sequences, all three controls low included
    m_prev = '0;
    for (int k = 0; k < 400; k++) begin
      logic [2:0] ctl;
      logic [AW-1:0] e;
      logic [AW-1:0] exp;
      ctl = 3'($urandom);
      e   = AW'($urandom);
      if (k % 50 == 7) ctl = 3'b000;
      if (k % 97 == 3) e = '1;
      apply(ctl[2], ctl[1], ctl[0], e);
      exp = model(ctl[2], ctl[1], ctl[0], e, m_prev);
      check("R8 random precedence", exp);
      m_prev = exp;
    end

    // long step run across wrap
    apply(1'b1, 1'b0, 1'b0, 14'h3FFD);
    check("R8 load over step", 14'h3FFD);
    apply(1'b1, 1'b1, 1'b0, 14'h0000); check("R5 step", 14'h3FFE);
    apply(1'b1, 1'b1, 1'b0, 14'h0000); check("R5 step to top", 14'h3FFF);
    apply(1'b1, 1'b1, 1'b0, 14'h0000); check("R6 wrap to zero", 14'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule